// File: doc/BRIEF.md
# ATA PIO Sector Transfer Engine

This block is the device side of an ATA-style disk interface in programmed-I/O mode. A host reads and writes a small task-file register set through a byte-wide command block with a 16-bit data port. The host loads a sector count, an LBA and a drive/head byte, then writes an opcode. The engine decodes the opcode and either finishes at once (non-data commands and the read-max-address query) or moves whole 512-byte sectors between the data port and an internal sector store. The store is a RAM addressed by LBA. Reads preload the first word of each sector before raising DRQ. Writes store each word as it arrives. Each sector hand-off goes through a short busy phase.

The store has a second port for maintenance. It has one cycle of read latency, so the surrounding system or a bench can fill and inspect sector contents. The engine handles only LBA addressing and 16-bit data accesses.

The control sequencer uses these states. IDLE waits for a command. NODATA is a one-cycle busy phase for immediate commands. RD_ISSUE and RD_LOAD fetch the first word of a sector. RD_XFER presents read data. WR_PREP is a one-cycle busy phase before the first write sector. WR_XFER accepts write data. WR_STORE is the busy/seek-complete phase after a sector is stored. WR_WAIT holds a later write sector behind an interrupt.

The transitions are:
- IDLE to NODATA on a non-data or read-max command.
- IDLE to RD_ISSUE on a read.
- IDLE to WR_PREP on a write.
- IDLE to IDLE on a rejected command.
- NODATA to IDLE.
- RD_ISSUE to RD_LOAD to RD_XFER.
- RD_XFER to RD_ISSUE after the last word of a sector when more sectors remain, or to IDLE after the final word.
- WR_PREP to WR_XFER.
- WR_XFER to WR_STORE after the last word of a sector.
- WR_STORE to WR_WAIT when sectors remain, or to IDLE when none remain.
- WR_WAIT to WR_XFER on a status read.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, the status register reads 0x40 and the error register reads 0x01. The interrupt output is low. Status bit positions are BSY=7, DRDY=6 (always 1), DF=5 (always 0), DSC=4, DRQ=3 and ERR=0.
- R2: The register offsets are 0 data, 1 error (read) / features (write), 2 sector count, 3 LBA[7:0], 4 LBA[15:8], 5 LBA[23:16], 6 drive/head and 7 status (read) / command (write). Any access with offset 8..15 raises the bad-offset output in the same cycle. Writes to features change no register.
- R3: A command written while IDLE and accepted sets BSY and clears DRQ, DF and ERR. It also clears the error register to 0x00 and drops the interrupt. Command writes outside IDLE are ignored.
- R4: A read (0x20, 0xC4) or write (0x30, 0xC5) with drive/head bit 6 clear, or any unknown opcode, is rejected. The engine stays IDLE with ERR set, the error register at 0x04 and the interrupt raised.
- R5: For a read, once the first word of a sector is loaded, BSY clears, DRQ sets and the interrupt rises. The data register already holds word 0. Each data read advances one word, provided the host leaves at least one idle cycle after each data read.
- R6: After the last word of a read sector, if more sectors remain the engine shows BSY with DRQ clear while it loads the next sector. After the last word of the final sector it returns to IDLE with status 0x40 and raises no interrupt.
- R7: For a write, the first sector is offered with DRQ and no interrupt. Each later sector waits in WR_WAIT with the interrupt raised until the host reads status. Data writes made while waiting are discarded.
- R8: After the 256th word of a written sector, BSY and DSC are set and DRQ is clear. DSC stays set until reset. When the final sector has been stored, the engine returns to IDLE and raises the interrupt.
- R9: A sector count of 0 transfers 256 sectors.
- R10: Opcode 0xF8 returns capacity-1 (capacity = 2^LBA_W sectors) as follows: bits 7:0 in offset 3, bits 15:8 in offset 4, bits 23:16 in offset 5, and bits 27:24 in the low nibble of offset 6. The upper nibble of offset 6 is kept.
- R11: Opcodes 0x10, 0xE3, 0xE0, 0xE7, 0x40, 0x70, 0xEF and 0xC6 complete after one busy cycle. They have no data phase and raise the interrupt.
- R12: A status read clears the interrupt. If the engine raises the interrupt in the same cycle, the raise wins.
- R13: Sector word w of LBA n sits at store address n*256+w, using the low LBA_W bits of the LBA. The maintenance port writes on the clock edge and returns read data one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 4 | Register offset |
| host_wdata | input | 16 | Write data (low byte for byte registers) |
| host_rdata | output | 16 | Read data for the addressed register |
| host_bad_ofs | output | 1 | Access to an undefined offset |
| intrq | output | 1 | Interrupt request |
| mnt_we | input | 1 | Maintenance write enable |
| mnt_addr | input | LBA_W+8 | Maintenance word address |
| mnt_wdata | input | 16 | Maintenance write data |
| mnt_rdata | output | 16 | Maintenance read data, one cycle latency |

## Verification
Assertions check the following on every cycle:
- an accepted command shows BSY without DRQ on the next cycle;
- a rejected one leaves ERR and the interrupt set;
- each read access moves the word pointer by one;
- a sector boundary yields a busy phase;
- a stored write sector shows BSY with seek-complete;
- WR_WAIT never sits without an interrupt;
- DRQ never appears with no sectors left;
- the read-max load lands in the address registers.

Only the bench scenarios can show the data content of the sectors moved in each direction, the discarding of stray writes while waiting, the full 256-sector count-zero run with LBA wrap in the store, and the exact status values seen between phases.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int WORD_BYTES   = 2;
    localparam int SECTOR_WORDS = SECTOR_BYTES / WORD_BYTES;
    localparam int WORD_W       = $clog2(SECTOR_WORDS);
    localparam int CNT_W        = WORD_W + 1;

    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_ERRFT  = 3'd1;
    localparam logic [2:0] OFS_COUNT  = 3'd2;
    localparam logic [2:0] OFS_LBA0   = 3'd3;
    localparam logic [2:0] OFS_LBA1   = 3'd4;
    localparam logic [2:0] OFS_LBA2   = 3'd5;
    localparam logic [2:0] OFS_DRIVE  = 3'd6;
    localparam logic [2:0] OFS_STATCMD = 3'd7;

    localparam int SB_BSY  = 7;
    localparam int SB_DRDY = 6;
    localparam int SB_DF   = 5;
    localparam int SB_DSC  = 4;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;
    localparam int DRV_LBA_BIT = 6;

    localparam logic [7:0] ERRREG_RESET = 8'h01;
    localparam logic [7:0] ERRREG_ABORT = 8'h04;

    typedef enum logic [3:0] {
        ST_IDLE, ST_NODATA, ST_RD_ISSUE, ST_RD_LOAD, ST_RD_XFER,
        ST_WR_PREP, ST_WR_XFER, ST_WR_STORE, ST_WR_WAIT
    } eng_state_e;

    typedef enum logic [2:0] {
        CK_REJECT, CK_NODATA, CK_MAXADDR, CK_READ, CK_WRITE
    } cmd_kind_e;

    function automatic cmd_kind_e classify(input logic [7:0] op, input logic lba_on);
        cmd_kind_e k;
        case (op)
            8'h20, 8'hC4: k = lba_on ? CK_READ  : CK_REJECT;
            8'h30, 8'hC5: k = lba_on ? CK_WRITE : CK_REJECT;
            8'hF8:        k = CK_MAXADDR;
            8'h10, 8'hE3, 8'hE0, 8'hE7,
            8'h40, 8'h70, 8'hEF, 8'hC6: k = CK_NODATA;
            default:      k = CK_REJECT;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_pio_pkg::*;
#(
    parameter int LBA_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_ofs,
    input  logic [7:0] wr_byte,
    input  logic       maxaddr_ld,
    output logic [7:0] count_q,
    output logic [7:0] lba0_q,
    output logic [7:0] lba1_q,
    output logic [7:0] lba2_q,
    output logic [7:0] drive_q
);

    localparam logic [27:0] CAP_M1 = 28'((64'd1 << LBA_W) - 64'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= 8'h00;
            lba0_q  <= 8'h00;
            lba1_q  <= 8'h00;
            lba2_q  <= 8'h00;
            drive_q <= 8'h00;
        end else if (maxaddr_ld) begin
            lba0_q       <= CAP_M1[7:0];
            lba1_q       <= CAP_M1[15:8];
            lba2_q       <= CAP_M1[23:16];
            drive_q[3:0] <= CAP_M1[27:24];
        end else if (wr_en) begin
            unique case (wr_ofs)
                OFS_COUNT: count_q <= wr_byte;
                OFS_LBA0:  lba0_q  <= wr_byte;
                OFS_LBA1:  lba1_q  <= wr_byte;
                OFS_LBA2:  lba2_q  <= wr_byte;
                OFS_DRIVE: drive_q <= wr_byte;
                default: ;
            endcase
        end
    end

    AST_MAXADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        maxaddr_ld |=> (lba0_q == CAP_M1[7:0] && lba1_q == CAP_M1[15:8] &&
                        lba2_q == CAP_M1[23:16] && drive_q[3:0] == CAP_M1[27:24])); // R10

endmodule

// File: rtl/ata_sector_store.sv
module ata_sector_store
    import ata_pio_pkg::*;
#(
    parameter int LBA_W = 3
) (
    input  logic                    clk,
    input  logic [LBA_W+WORD_W-1:0] e_addr,
    input  logic                    e_we,
    input  logic [15:0]             e_wdata,
    output logic [15:0]             e_rdata,
    input  logic                    m_we,
    input  logic [LBA_W+WORD_W-1:0] m_addr,
    input  logic [15:0]             m_wdata,
    output logic [15:0]             m_rdata
);

    localparam int AW    = LBA_W + WORD_W;
    localparam int DEPTH = 1 << AW;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (e_we) begin
            mem[e_addr] <= e_wdata;
        end else if (m_we) begin
            mem[m_addr] <= m_wdata;
        end
        e_rdata <= mem[e_addr];
        m_rdata <= mem[m_addr];
    end

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
    import ata_pio_pkg::*;
#(
    parameter int LBA_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [7:0]              cmd_code,
    input  logic                    lba_mode,
    input  logic [LBA_W-1:0]        lba_lo,
    input  logic [7:0]              count,
    input  logic                    dat_rd,
    input  logic                    dat_wr,
    input  logic [15:0]             dat_wdata,
    input  logic                    st_rd,
    input  logic [15:0]             ram_rdata,
    output logic [LBA_W+WORD_W-1:0] ram_addr,
    output logic                    ram_we,
    output logic [15:0]             ram_wdata,
    output logic [15:0]             data_q,
    output logic                    bsy,
    output logic                    drq,
    output logic                    dsc_q,
    output logic                    err_q,
    output logic [7:0]              errreg_q,
    output logic                    intrq_q,
    output logic                    maxaddr_ld
);

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(SECTOR_WORDS - 1);
    localparam logic [WORD_W-1:0] WORD_ONE  = WORD_W'(1);
    localparam logic [LBA_W-1:0]  LBA_ONE   = LBA_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(SECTOR_WORDS);

    eng_state_e        state, nxt;
    cmd_kind_e         kind;
    logic [LBA_W-1:0]  cur_lba;
    logic [CNT_W-1:0]  sec_left;
    logic [WORD_W-1:0] word_idx;
    logic              load_pend;
    logic              accept, word_last, rd_step, wr_step;
    logic              intr_set, intr_clr;

    assign kind      = classify(cmd_code, lba_mode);
    assign accept    = (state == ST_IDLE) && cmd_wr;
    assign word_last = (word_idx == LAST_WORD);
    assign rd_step   = (state == ST_RD_XFER) && dat_rd;
    assign wr_step   = (state == ST_WR_XFER) && dat_wr;
    assign maxaddr_ld = accept && (kind == CK_MAXADDR);

    assign bsy = (state == ST_NODATA) || (state == ST_RD_ISSUE) || (state == ST_RD_LOAD) ||
                 (state == ST_WR_PREP) || (state == ST_WR_STORE);
    assign drq = (state == ST_RD_XFER) || (state == ST_WR_XFER) || (state == ST_WR_WAIT);

    assign ram_we    = wr_step;
    assign ram_wdata = dat_wdata;
    assign ram_addr  = (state == ST_RD_XFER) ? {cur_lba, word_idx + WORD_ONE}
                                             : {cur_lba, word_idx};

    // next-state process
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    unique case (kind)
                        CK_NODATA, CK_MAXADDR: nxt = ST_NODATA;
                        CK_READ:               nxt = ST_RD_ISSUE;
                        CK_WRITE:              nxt = ST_WR_PREP;
                        default:               nxt = ST_IDLE;
                    endcase
                end
            end
            ST_NODATA:   nxt = ST_IDLE;
            ST_RD_ISSUE: nxt = ST_RD_LOAD;
            ST_RD_LOAD:  nxt = ST_RD_XFER;
            ST_RD_XFER: begin
                if (dat_rd && word_last)
                    nxt = (sec_left == CNT_ONE) ? ST_IDLE : ST_RD_ISSUE;
            end
            ST_WR_PREP:  nxt = ST_WR_XFER;
            ST_WR_XFER: begin
                if (dat_wr && word_last) nxt = ST_WR_STORE;
            end
            ST_WR_STORE: nxt = (sec_left == '0) ? ST_IDLE : ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (st_rd) nxt = ST_WR_XFER;
            end
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign intr_set = (state == ST_NODATA) || (state == ST_RD_LOAD) ||
                      (state == ST_WR_STORE) || (accept && kind == CK_REJECT);
    assign intr_clr = st_rd || accept;

    // datapath and flag process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lba   <= '0;
            sec_left  <= '0;
            word_idx  <= '0;
            load_pend <= 1'b0;
            data_q    <= '0;
            dsc_q     <= 1'b0;
            err_q     <= 1'b0;
            errreg_q  <= ERRREG_RESET;
            intrq_q   <= 1'b0;
        end else begin
            load_pend <= rd_step && !word_last;
            if (intr_set)      intrq_q <= 1'b1;
            else if (intr_clr) intrq_q <= 1'b0;

            if (accept) begin
                err_q    <= (kind == CK_REJECT);
                errreg_q <= (kind == CK_REJECT) ? ERRREG_ABORT : 8'h00;
                cur_lba  <= lba_lo;
                sec_left <= (count == 8'h00) ? CNT_FULL : {1'b0, count};
                word_idx <= '0;
            end

            if ((state == ST_RD_LOAD) || load_pend) data_q <= ram_rdata;

            if (rd_step || wr_step) begin
                word_idx <= word_idx + WORD_ONE;
                if (word_last) begin
                    sec_left <= sec_left - CNT_ONE;
                    cur_lba  <= cur_lba + LBA_ONE;
                end
            end
            if (wr_step && word_last) dsc_q <= 1'b1;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind != CK_REJECT) |=> (bsy && !drq)); // R3
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == CK_REJECT) |=> (err_q && intrq_q && !bsy && !drq)); // R4
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !word_last) |=> (drq && word_idx == $past(word_idx) + WORD_ONE)); // R5
    AST_READ_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && word_last && sec_left != CNT_ONE) |=> (bsy && !drq)); // R6
    AST_WAIT_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_WAIT) |-> intrq_q); // R7
    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && word_last) |=> (bsy && dsc_q && !drq)); // R8
    AST_DRQ_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (sec_left != '0)); // R9

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int LBA_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_sel,
    input  logic                    host_wr,
    input  logic [3:0]              host_ofs,
    input  logic [15:0]             host_wdata,
    output logic [15:0]             host_rdata,
    output logic                    host_bad_ofs,
    output logic                    intrq,
    input  logic                    mnt_we,
    input  logic [LBA_W+WORD_W-1:0] mnt_addr,
    input  logic [15:0]             mnt_wdata,
    output logic [15:0]             mnt_rdata
);

    localparam int AW = LBA_W + WORD_W;

    logic          defined, acc_wr, acc_rd;
    logic [2:0]    ofs;
    logic [7:0]    count_q, lba0_q, lba1_q, lba2_q, drive_q;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [15:0]   ram_wdata, ram_rdata, data_q;
    logic          bsy, drq, dsc_q, err_q, intrq_q, maxaddr_ld;
    logic [7:0]    errreg_q, status;

    assign defined      = !host_ofs[3];
    assign ofs          = host_ofs[2:0];
    assign host_bad_ofs = host_sel && !defined;
    assign acc_wr       = host_sel && defined && host_wr;
    assign acc_rd       = host_sel && defined && !host_wr;
    assign intrq        = intrq_q;

    always_comb begin
        status          = 8'h00;
        status[SB_BSY]  = bsy;
        status[SB_DRDY] = 1'b1;
        status[SB_DF]   = 1'b0;
        status[SB_DSC]  = dsc_q;
        status[SB_DRQ]  = drq;
        status[SB_ERR]  = err_q;
    end

    always_comb begin
        host_rdata = 16'h0000;
        if (acc_rd) begin
            unique case (ofs)
                OFS_DATA:    host_rdata = data_q;
                OFS_ERRFT:   host_rdata = {8'h00, errreg_q};
                OFS_COUNT:   host_rdata = {8'h00, count_q};
                OFS_LBA0:    host_rdata = {8'h00, lba0_q};
                OFS_LBA1:    host_rdata = {8'h00, lba1_q};
                OFS_LBA2:    host_rdata = {8'h00, lba2_q};
                OFS_DRIVE:   host_rdata = {8'h00, drive_q};
                OFS_STATCMD: host_rdata = {8'h00, status};
                default:     host_rdata = 16'h0000;
            endcase
        end
    end

    ata_taskfile_regs #(.LBA_W(LBA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (acc_wr),
        .wr_ofs     (ofs),
        .wr_byte    (host_wdata[7:0]),
        .maxaddr_ld (maxaddr_ld),
        .count_q    (count_q),
        .lba0_q     (lba0_q),
        .lba1_q     (lba1_q),
        .lba2_q     (lba2_q),
        .drive_q    (drive_q)
    );

    ata_pio_fsm #(.LBA_W(LBA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (acc_wr && ofs == OFS_STATCMD),
        .cmd_code   (host_wdata[7:0]),
        .lba_mode   (drive_q[DRV_LBA_BIT]),
        .lba_lo     (lba0_q[LBA_W-1:0]),
        .count      (count_q),
        .dat_rd     (acc_rd && ofs == OFS_DATA),
        .dat_wr     (acc_wr && ofs == OFS_DATA),
        .dat_wdata  (host_wdata),
        .st_rd      (acc_rd && ofs == OFS_STATCMD),
        .ram_rdata  (ram_rdata),
        .ram_addr   (ram_addr),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata),
        .data_q     (data_q),
        .bsy        (bsy),
        .drq        (drq),
        .dsc_q      (dsc_q),
        .err_q      (err_q),
        .errreg_q   (errreg_q),
        .intrq_q    (intrq_q),
        .maxaddr_ld (maxaddr_ld)
    );

    ata_sector_store #(.LBA_W(LBA_W)) u_store (
        .clk     (clk),
        .e_addr  (ram_addr),
        .e_we    (ram_we),
        .e_wdata (ram_wdata),
        .e_rdata (ram_rdata),
        .m_we    (mnt_we),
        .m_addr  (mnt_addr),
        .m_wdata (mnt_wdata),
        .m_rdata (mnt_rdata)
    );

    AST_BAD_OFS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_bad_ofs && host_wr) |=> $stable(count_q) && $stable(drive_q)); // R2

endmodule

// File: tb/ata_pio_engine_tb.sv
module ata_pio_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LBA_W = 3;
    localparam int NSEC  = 1 << LBA_W;
    localparam int NWORD = NSEC * 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [3:0]  host_ofs = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_bad_ofs, intrq;
    logic        mnt_we = 1'b0;
    logic [LBA_W+7:0] mnt_addr = '0;
    logic [15:0] mnt_wdata = '0;
    logic [15:0] mnt_rdata;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [NWORD];

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_engine #(.LBA_W(LBA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_bad_ofs(host_bad_ofs), .intrq(intrq), .mnt_we(mnt_we),
        .mnt_addr(mnt_addr), .mnt_wdata(mnt_wdata), .mnt_rdata(mnt_rdata)
    );

    function automatic logic [15:0] pat(input int a, input int b, input int seed);
        return 16'((a * 16'h0313) ^ (b * 16'h0047) ^ (seed * 16'h1B00) ^ 16'hA5C3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock reference for the offset decode (R2)
    always @(posedge clk) begin
        if (rst_n && host_sel) begin
            checks++;
            if (host_bad_ofs !== host_ofs[3]) begin
                fails++;
                $display("FAIL R2 bad_ofs actual=%b expected=%b", host_bad_ofs, host_ofs[3]);
            end
        end
    end

    task automatic hw(input logic [3:0] o, input logic [15:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_ofs = o; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hr(input logic [3:0] o, output logic [15:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = o;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (intrq !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {31'd0, intrq}, 32'd1);
    endtask

    task automatic mrd(input int a, output logic [15:0] d);
        @(negedge clk);
        mnt_addr = (LBA_W+8)'(a);
        @(negedge clk);
        d = mnt_rdata;
    endtask

    task automatic write_sector(input int lba, input int seed, input bit probe);
        for (int w = 0; w < 256; w++) begin
            logic [15:0] v;
            v = pat(lba, w, seed);
            model[(lba % NSEC) * 256 + w] = v;
            if (w == 255 && probe) begin
                @(negedge clk);
                host_sel = 1'b1; host_wr = 1'b1; host_ofs = 4'd0; host_wdata = v;
                @(negedge clk);
                host_wr = 1'b0; host_ofs = 4'd7;
                #1 chk("R8 status after stored sector", {24'd0, host_rdata[7:0]}, 32'hD0);
                @(negedge clk);
                host_sel = 1'b0;
            end else begin
                hw(4'd0, v);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int bad;

        for (int i = 0; i < NWORD; i++) model[i] = pat(i / 256, i % 256, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // preload the store (R13)
        for (int i = 0; i < NWORD; i++) begin
            @(negedge clk);
            mnt_we = 1'b1; mnt_addr = (LBA_W+8)'(i); mnt_wdata = model[i];
        end
        @(negedge clk);
        mnt_we = 1'b0;
        mrd(5 * 256 + 17, d);
        chk("R13 maintenance readback", {16'd0, d}, {16'd0, model[5*256+17]});

        // R1 reset state
        chk("R1 intrq after reset", {31'd0, intrq}, 32'd0);
        hr(4'd7, d); chk("R1 status after reset", {16'd0, d}, 32'h40);
        hr(4'd1, d); chk("R1 error after reset", {16'd0, d}, 32'h01);

        // R2 features ignored, undefined offsets flagged
        hw(4'd2, 16'h0003);
        hw(4'd1, 16'h0055);
        hr(4'd1, d); chk("R2 features write ignored (error reg)", {16'd0, d}, 32'h01);
        hr(4'd2, d); chk("R2 features write ignored (count)", {16'd0, d}, 32'h03);
        hw(4'd9, 16'h00FF);
        hr(4'd2, d); chk("R2 undefined offset write ignored", {16'd0, d}, 32'h03);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = 4'd12;
        #1 chk("R2 bad offset flagged", {31'd0, host_bad_ofs}, 32'd1);
        @(negedge clk);
        host_sel = 1'b0;

        // R10 read max address
        hw(4'd6, 16'h00EF);
        hw(4'd7, 16'h00F8);
        @(negedge clk);
        chk("R10 read-max completion interrupt", {31'd0, intrq}, 32'd1);
        hr(4'd3, d); chk("R10 bits 7:0", {16'd0, d}, NSEC - 1);
        hr(4'd4, d); chk("R10 bits 15:8", {16'd0, d}, 32'h00);
        hr(4'd5, d); chk("R10 bits 23:16", {16'd0, d}, 32'h00);
        hr(4'd6, d); chk("R10 head nibble", {16'd0, d}, 32'hE0);
        hr(4'd7, d); chk("R10 status", {16'd0, d}, 32'h40);
        chk("R12 status read clears interrupt", {31'd0, intrq}, 32'd0);

        // R4 rejections
        hw(4'd6, 16'h00A0);
        hw(4'd7, 16'h0020);
        chk("R4 reject interrupt", {31'd0, intrq}, 32'd1);
        hr(4'd7, d); chk("R4 reject status", {16'd0, d}, 32'h41);
        hr(4'd1, d); chk("R4 reject error reg", {16'd0, d}, 32'h04);
        hw(4'd6, 16'h00E0);
        hw(4'd7, 16'h0099);
        hr(4'd7, d); chk("R4 unknown opcode status", {16'd0, d}, 32'h41);

        // R11 non-data command, R3 error cleared on accept
        hw(4'd7, 16'h00E7);
        chk("R3 accept clears interrupt", {31'd0, intrq}, 32'd0);
        @(negedge clk);
        chk("R11 non-data interrupt", {31'd0, intrq}, 32'd1);
        hr(4'd7, d); chk("R11 non-data status, R3 ERR cleared", {16'd0, d}, 32'h40);
        hr(4'd1, d); chk("R3 error reg cleared", {16'd0, d}, 32'h00);

        // R5/R6 two-sector read from LBA 5
        hw(4'd2, 16'h0002);
        hw(4'd3, 16'h0005);
        hw(4'd4, 16'h0000);
        hw(4'd5, 16'h0000);
        hw(4'd7, 16'h0020);
        hr(4'd7, d); chk("R3 busy after read accept", {16'd0, d}, 32'hC0);
        wait_irq("R5 data-ready interrupt");
        hr(4'd7, d); chk("R5 DRQ status", {16'd0, d}, 32'h48);
        chk("R12 interrupt cleared", {31'd0, intrq}, 32'd0);
        for (int s = 0; s < 2; s++) begin
            bad = 0;
            for (int w = 0; w < 256; w++) begin
                if (w == 255 && s == 0) begin
                    @(negedge clk);
                    host_sel = 1'b1; host_wr = 1'b0; host_ofs = 4'd0;
                    #1 d = host_rdata;
                    @(negedge clk);
                    host_ofs = 4'd7;
                    #1 chk("R6 busy between read sectors", {16'd0, host_rdata}, 32'hC0);
                    @(negedge clk);
                    host_sel = 1'b0;
                end else begin
                    hr(4'd0, d);
                end
                if (w == 0 && s == 0) chk("R5 first word preloaded", {16'd0, d}, {16'd0, model[5*256]});
                if (d !== model[(5 + s) * 256 + w]) bad++;
            end
            chk("R5 sector read data mismatches", bad, 0);
            if (s == 0) begin
                wait_irq("R6 next sector interrupt");
                hr(4'd7, d); chk("R6 next sector DRQ", {16'd0, d}, 32'h48);
            end
        end
        @(negedge clk);
        chk("R6 no interrupt on read completion", {31'd0, intrq}, 32'd0);
        hr(4'd7, d); chk("R6 idle after read", {16'd0, d}, 32'h40);

        // R7/R8 two-sector write to LBA 2
        hw(4'd3, 16'h0002);
        hw(4'd7, 16'h0030);
        hr(4'd7, d); chk("R7 first write sector offered", {16'd0, d}, 32'h48);
        chk("R7 no interrupt for first sector", {31'd0, intrq}, 32'd0);
        write_sector(2, 7, 1'b1);
        chk("R7 later sector interrupt", {31'd0, intrq}, 32'd1);
        hw(4'd0, 16'hDEAD);
        hr(4'd7, d); chk("R7 waiting status", {16'd0, d}, 32'h58);
        write_sector(3, 7, 1'b0);
        @(negedge clk);
        chk("R8 write completion interrupt", {31'd0, intrq}, 32'd1);
        hr(4'd7, d); chk("R8 idle status with DSC", {16'd0, d}, 32'h50);
        mrd(3 * 256, d);
        chk("R7 stray write discarded", {16'd0, d}, {16'd0, pat(3, 0, 7)});
        bad = 0;
        for (int i = 0; i < NWORD; i++) begin
            mrd(i, d);
            if (d !== model[i]) bad++;
        end
        chk("R13 store contents after write", bad, 0);

        // R9 count 0 means 256 sectors (LBA wraps in the store)
        hw(4'd2, 16'h0000);
        hw(4'd3, 16'h0000);
        hw(4'd7, 16'h00C5);
        for (int s = 0; s < 256; s++) begin
            if (s > 0) begin
                wait_irq("R9 sector interrupt");
                hr(4'd7, d);
                if (s == 255) chk("R9 still transferring after 255 sectors", {16'd0, d}, 32'h58);
            end
            write_sector(s, 9, 1'b0);
        end
        @(negedge clk);
        hr(4'd7, d); chk("R9 complete after 256 sectors", {16'd0, d}, 32'h50);
        bad = 0;
        for (int i = 0; i < NWORD; i++) begin
            mrd(i, d);
            if (d !== model[i]) bad++;
        end
        chk("R9 store contents after 256-sector write", bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule